// File: doc/BRIEF.md
# Output Port Latch with Set, Clear and Toggle Aliases

This block holds the output state of a small general-purpose port, eight pins by default. Software changes that state through a simple synchronous register interface. A plain data register loads every latch bit at once. Three write-only alias registers act only on the bits written as one: one forces those bits high, one forces them low, and one inverts them. A read-modify-write sequence is therefore never needed to change a single pin.

A direction register decides, pin by pin, whether the port drives the pin. The latch accepts updates whatever the direction. A level stored while a pin is an input is kept, and it appears on the pin as soon as that pin is made an output. Only one register is accessed per cycle, so alias writes never collide.

Top module: `gpio_out_port`

## Requirements
- R1: After a synchronous active-low reset, the output latch and the direction register are all zeros, so `pin_oe` and `pin_out` are zero.
- R2: A write to the set alias (address 2) forces every latch bit whose write-data bit is 1 to high.
- R3: A write to the clear alias (address 3) forces every latch bit whose write-data bit is 1 to low.
- R4: A write to the toggle alias (address 4) inverts every latch bit whose write-data bit is 1.
- R5: Latch bits whose write-data bit is 0 keep their value on any alias write.
- R6: A read of address 2, 3 or 4 always returns zero.
- R7: The data register (address 0) reads back the latch in bits PINS-1..0. A write to it loads all latch bits from the write data.
- R8: The direction register (address 1) reads back and drives `pin_oe`, one bit per pin. A bit value of 1 means output.
- R9: `pin_out` equals the latch on pins whose `pin_oe` is 1 and is 0 elsewhere. The latch updates even while a pin is an input, and the stored value appears on `pin_out` once the pin becomes an output.
- R10: Bits 31..PINS of every register read as zero, and writes to them are ignored. Addresses 5..7 read as zero, and writes to them change nothing.
- R11: A write takes effect at the rising clock edge on which `wr_en` is sampled high. The new value is visible on the read data and on the pins right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address: 0 data, 1 direction, 2 set, 3 clear, 4 toggle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_out | output | PINS | Driven level for each pin |
| pin_oe | output | PINS | Output enable for each pin |

## Verification
The bench steps through all 256 byte values. For each value it sets up a different starting latch, direction and alias mask, then applies a set, a clear and a toggle. The masks mix ones and zeros, so one check tells acting bits apart from untouched bits. The directions vary, so masked pins can be compared with driven pins. Further patterns set all upper bits and use unmapped addresses to show that those have no effect. A separate sequence stores a value while all pins are inputs, then turns the pins to outputs to show that the stored value persists.

// File: rtl/gpio_out_pkg.sv
// Shared constants and types for the output port.
// Assumes word-indexed register addresses and one access per cycle.
package gpio_out_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 3'd0,
        A_DIR  = 3'd1,
        A_SET  = 3'd2,
        A_CLR  = 3'd3,
        A_TGL  = 3'd4
    } reg_addr_e;

    // One strobe per writable register; at most one is high in a cycle.
    typedef struct packed {
        logic data;
        logic dir;
        logic set;
        logic clr;
        logic tgl;
    } wr_stb_t;

endpackage

// File: rtl/gpio_wr_decode.sv
// Turns the write strobe and address into one strobe per register.
// Assumes unmapped addresses must produce no strobe.
module gpio_wr_decode
    import gpio_out_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_stb_t           stb
);

    // Decode the address into register strobes.
    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                A_DATA:  stb.data = 1'b1;
                A_DIR:   stb.dir  = 1'b1;
                A_SET:   stb.set  = 1'b1;
                A_CLR:   stb.clr  = 1'b1;
                A_TGL:   stb.tgl  = 1'b1;
                default: stb      = '0;
            endcase
        end
    end

    // R10: an unmapped address raises no strobe.
    always_comb begin
        if (addr > ADDR_W'(4)) begin
            p_no_stb_unmapped_r10: assert (stb == '0);
        end
    end

endmodule

// File: rtl/gpio_latch_bank.sv
// Output data latch, one flop per pin, updated by a data load or by
// the set, clear and toggle aliases. Assumes that at most one strobe is high.
module gpio_latch_bank
    import gpio_out_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wr_stb_t         stb,
    input  logic [PINS-1:0] wbits,
    output logic [PINS-1:0] q
);

    for (genvar i = 0; i < PINS; i++) begin : g_bit
        logic nxt;

        // Choose the next value for this bit.
        always_comb begin
            nxt = q[i];
            if (stb.data)                 nxt = wbits[i];
            else if (stb.set && wbits[i]) nxt = 1'b1;
            else if (stb.clr && wbits[i]) nxt = 1'b0;
            else if (stb.tgl && wbits[i]) nxt = ~q[i];
        end

        // Store the bit; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= nxt;
        end

        p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (stb.set && wbits[i]) |=> q[i]);
        p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (stb.clr && wbits[i]) |=> !q[i]);
        p_tgl_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stb.tgl && wbits[i]) |=> (q[i] != $past(q[i])));
        p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((stb.set || stb.clr || stb.tgl) && !wbits[i]) |=> $stable(q[i]));
        p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            stb.data |=> (q[i] == $past(wbits[i])));
    end

    p_one_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

endmodule

// File: rtl/gpio_dir_reg.sv
// Direction register: one bit per pin, 1 means the pin is driven.
// Assumes a reset to all inputs.
module gpio_dir_reg
    import gpio_out_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wr_stb_t         stb,
    input  logic [PINS-1:0] wbits,
    output logic [PINS-1:0] dir
);

    // Load the direction bits on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir <= '0;
        else if (stb.dir) dir <= wbits;
    end

    p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.dir |=> $stable(dir));

endmodule

// File: rtl/gpio_read_mux.sv
// Combinational read-back. Aliases and unmapped addresses return zero,
// and the upper bits are always zero.
module gpio_read_mux
    import gpio_out_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   latch,
    input  logic [PINS-1:0]   dir,
    output logic [REG_W-1:0]  rdata
);

    // Select the register addressed for read.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_DATA:  rdata[PINS-1:0] = latch;
            A_DIR:   rdata[PINS-1:0] = dir;
            default: rdata = '0;
        endcase
    end

    // R6: alias reads return zero. R10: upper bits are always zero.
    always_comb begin
        if (addr >= ADDR_W'(2)) begin
            p_alias_zero_r6: assert (rdata == '0);
        end
        p_upper_zero_r10: assert (rdata[REG_W-1:PINS] == '0);
    end

endmodule

// File: rtl/gpio_out_port.sv
// Top level of the output port. It ties together the write decode, the
// latch bank, the direction register and the read mux, and masks the
// driven level by direction. Assumes 1 <= PINS < 32.
module gpio_out_port
    import gpio_out_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    wr_stb_t         stb;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;
    logic            unused_hi;

    assign unused_hi = ^wdata[REG_W-1:PINS];

    gpio_wr_decode i_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .stb   (stb)
    );

    gpio_latch_bank #(.PINS(PINS)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .wbits (wdata[PINS-1:0]),
        .q     (latch_q)
    );

    gpio_dir_reg #(.PINS(PINS)) i_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .wbits (wdata[PINS-1:0]),
        .dir   (dir_q)
    );

    gpio_read_mux #(.PINS(PINS)) i_rd (
        .addr  (addr),
        .latch (latch_q),
        .dir   (dir_q),
        .rdata (rdata)
    );

    // Drive only the pins configured as outputs.
    always_comb begin
        pin_oe  = dir_q;
        pin_out = latch_q & dir_q;
    end

    p_oe_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> (pin_oe == $past(wdata[PINS-1:0])));
    p_out_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && pin_oe == '1 && $stable(pin_oe))
            |=> ((pin_out & $past(wdata[PINS-1:0])) == $past(wdata[PINS-1:0])));
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > 3'd4) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/test_gpio_out_port.sv
// Sweeps all byte masks through the set/clear/toggle aliases with varied
// starting latch and direction, checking against an arithmetic model.
module test_gpio_out_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int errs   = 0;
    logic [7:0] m_lat = '0;
    logic [7:0] m_dir = '0;

    always #4 clk = ~clk;

    gpio_out_port #(.PINS(8)) i_gpio_out_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk_state(input string tag);
        logic [31:0] v;
        rd(3'd0, v);
        chk({tag, " data"}, v, {24'h0, m_lat});
        chk({tag, " R9 pin_out"}, {24'h0, pin_out}, {24'h0, m_lat & m_dir});
        chk({tag, " R8 pin_oe"}, {24'h0, pin_oe}, {24'h0, m_dir});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk_state("R1 reset");
        rd(3'd1, v);
        chk("R1 dir reset", v, 32'h0);

        // R2 R3 R4 R5 R7 R8 R9: sweep every mask byte
        for (int m = 0; m < 256; m++) begin
            m_lat = 8'((m * 37) ^ 8'h5A);
            m_dir = 8'(m);
            wr(3'd0, {24'h0, m_lat});
            wr(3'd1, {24'h0, m_dir});
            chk_state("R7 load");
            k = 8'(m ^ 8'hC3);
            wr(3'd2, {24'h0, k});
            m_lat = m_lat | k;
            chk_state("R2 set/R5 hold");
            k = 8'((m * 5) ^ 8'h3C);
            wr(3'd3, {24'h0, k});
            m_lat = m_lat & ~k;
            chk_state("R3 clear/R5 hold");
            k = 8'(m);
            wr(3'd4, {24'h0, k});
            m_lat = m_lat ^ k;
            chk_state("R4 toggle/R5 hold R11");
            rd(3'd1, v);
            chk("R8 dir read", v, {24'h0, m_dir});
            for (int a = 2; a <= 4; a++) begin
                rd(3'(a), v);
                chk("R6 alias read", v, 32'h0);
            end
        end

        // R9: persistence while input, then visible once output
        wr(3'd1, 32'h0);
        m_dir = 8'h00;
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0000_00A5);
        m_lat = 8'hA5;
        chk_state("R9 stored while input");
        wr(3'd1, 32'h0000_00FF);
        m_dir = 8'hFF;
        chk_state("R9 visible as output");

        // R10: reserved upper bits and unmapped addresses
        wr(3'd0, 32'hFFFF_FF3C);
        m_lat = 8'h3C;
        rd(3'd0, v);
        chk("R10 data upper", v, 32'h0000_003C);
        wr(3'd1, 32'hFFFF_FF0F);
        m_dir = 8'h0F;
        rd(3'd1, v);
        chk("R10 dir upper", v, 32'h0000_000F);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0000_0000);
        wr(3'd7, 32'hFFFF_FFFF);
        chk_state("R10 unmapped writes");
        for (int a = 5; a <= 7; a++) begin
            rd(3'(a), v);
            chk("R10 unmapped read", v, 32'h0);
        end

        // R1: reset returns to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_lat = '0;
        m_dir = '0;
        #1;
        chk_state("R1 reset again");

        finish_run();
    end

endmodule